// File: doc/BRIEF.md
# Local-Bus Master Preemption Arbiter

This block decides which of up to three local bus masters, or a DMA controller, owns a shared local bus. Every request and grant is active-low. A master keeps the bus for a guaranteed minimum tenure before a competing local master can take it. A DMA request takes the bus away at once, with no regard to tenure. Ownership never passes in a single step. The arbiter first withdraws the current grant and waits until that master has let go of its request. Only then does it grant the next requester. At least one clock with no grant at all separates any two owners.

A configuration input selects whether two or three request/grant pairs are active. Among waiting local masters the next owner is chosen in round-robin order, starting with the master after the last owner. When a DMA request and local requests are pending together, the DMA controller wins.

Top module: `lbus_preempt_arb`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, every local grant and the DMA grant are high (inactive).
- R2: At most one of the local grants and the DMA grant is low in any cycle.
- R3: When any grant goes low, no grant was low in the previous cycle.
- R4: On an idle bus, a local request that is sampled low at a clock edge is answered by its grant going low right after that edge.
- R5: While a competing local request is present, an owner that keeps requesting holds its grant for at least 31 clocks. The count starts with the first cycle its grant is low. With competition present from the start, the grant is withdrawn after exactly 31 cycles.
- R6: After a grant is withdrawn, no other local grant is given while the former owner's request stays low. The next grant goes low one clock after the release is sampled.
- R7: Waiting local masters are served round-robin, beginning with the index after the last owner and wrapping from the highest enabled index to 0.
- R8: If an owner raises its request, its grant goes high after the next edge. A waiting master is granted one edge later, with no wait for tenure.
- R9: A DMA request sampled low while a local grant is low withdraws that grant after the same edge, whatever its tenure.
- R10: The DMA grant goes low only after the preempted master has released. It stays low until the DMA request goes high. A pending DMA request is served ahead of local requests.
- R11: The configuration input num_en_i counts the enabled pairs: value 2 enables pairs 0 and 1, and value 3 enables all three. Values below 2 act as 2, and values above the master count act as the master count. The request of a disabled pair is ignored, and its grant stays high.
- R12: An owner that has no competing request keeps its grant for as long as it requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | NUM_MASTERS | Local master requests, active low |
| num_en_i | input | CFG_W | Number of enabled request/grant pairs (2 or 3) |
| dma_req_ni | input | 1 | DMA controller request, active low |
| gnt_no | output | NUM_MASTERS | Local master grants, active low |
| dma_gnt_no | output | 1 | DMA controller grant, active low |

## Verification
The bound checker evaluates these properties on every cycle:
- at most one grant is low (one-hot-or-none);
- a grant never goes low in the cycle right after another grant was low;
- a withdrawal forced by competition never comes before 31 grant cycles;
- a DMA request removes a local grant at the next edge;
- the DMA grant is held while its request is low;
- a disabled pair is never newly granted.

Other behaviour depends on how the masters behave, so only the bench scenarios can show it. This covers the exact 31-cycle length of a contended tenure and waiting for the former owner's release before the next grant. It also covers round-robin order with wrap-around, immediate handover on an early release, and DMA priority over waiting local masters.

// File: rtl/lbus_arb_pkg.sv
package lbus_arb_pkg;

    // Arbiter control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no owner, free to pick
        ST_OWN   = 2'd1,  // a local master holds the bus
        ST_DRAIN = 2'd2,  // grant withdrawn, waiting for owner release
        ST_DMA   = 2'd3   // DMA controller holds the bus
    } arb_state_e;

    localparam int unsigned MIN_ENABLED = 2;

endpackage

// File: rtl/lbus_arb_enmask.sv
module lbus_arb_enmask #(
    parameter int unsigned NUM_MASTERS = 3,
    parameter int unsigned CFG_W       = 2
) (
    input  logic [CFG_W-1:0]       num_en_i,
    output logic [NUM_MASTERS-1:0] en_mask_o
);
    import lbus_arb_pkg::*;

    int eff_cnt;

    // Clamp the requested count into the legal range
    always_comb begin
        eff_cnt = int'(num_en_i);
        if (eff_cnt < int'(MIN_ENABLED)) eff_cnt = int'(MIN_ENABLED);
        if (eff_cnt > int'(NUM_MASTERS)) eff_cnt = int'(NUM_MASTERS);
    end

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_mask
        assign en_mask_o[g] = (g < eff_cnt);
    end

endmodule

// File: rtl/lbus_arb_rrpick.sv
module lbus_arb_rrpick #(
    parameter int unsigned NUM_MASTERS = 3,
    localparam int unsigned IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic [NUM_MASTERS-1:0] req_i,   // active-high, already masked
    input  logic [IW-1:0]          last_i,  // previous owner
    output logic                   valid_o,
    output logic [IW-1:0]          idx_o
);
    int cand;

    // Walk from farthest to nearest so the nearest requester after last_i wins
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        cand    = 0;
        for (int k = NUM_MASTERS; k >= 1; k--) begin
            cand = int'(last_i) + k;
            if (cand >= int'(NUM_MASTERS)) cand = cand - int'(NUM_MASTERS);
            if (req_i[cand]) begin
                valid_o = 1'b1;
                idx_o   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/lbus_arb_tenure.sv
module lbus_arb_tenure #(
    parameter int unsigned TENURE = 31,
    localparam int unsigned CW = $clog2(TENURE + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,    // a new grant takes effect after this edge
    input  logic run_i,      // owner currently holds the grant
    output logic expired_o   // owner has held the grant TENURE cycles
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(1);
        end else if (run_i && (cnt_q < CW'(TENURE))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= CW'(TENURE));

endmodule

// File: rtl/lbus_preempt_arb.sv
module lbus_preempt_arb #(
    parameter int unsigned NUM_MASTERS = 3,
    parameter int unsigned TENURE      = 31,
    parameter int unsigned CFG_W       = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_MASTERS-1:0] req_ni,
    input  logic [CFG_W-1:0]       num_en_i,
    input  logic                   dma_req_ni,
    output logic [NUM_MASTERS-1:0] gnt_no,
    output logic                   dma_gnt_no
);
    import lbus_arb_pkg::*;

    localparam int unsigned IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    typedef struct packed {
        arb_state_e             state;
        logic [IW-1:0]          owner;
        logic [IW-1:0]          last;
        logic [NUM_MASTERS-1:0] gnt;
        logic                   dma_gnt;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [NUM_MASTERS-1:0] en_mask;
    logic [NUM_MASTERS-1:0] req_act;
    logic [NUM_MASTERS-1:0] owner_oh;
    logic [NUM_MASTERS-1:0] others;
    logic [NUM_MASTERS-1:0] pick_oh;
    logic                   owner_req;
    logic                   dma_req;
    logic                   pick_valid;
    logic [IW-1:0]          pick_idx;
    logic                   tenure_start;
    logic                   tenure_expired;
    logic                   pick_ok;

    lbus_arb_enmask #(
        .NUM_MASTERS(NUM_MASTERS),
        .CFG_W      (CFG_W)
    ) enmask_i (
        .num_en_i (num_en_i),
        .en_mask_o(en_mask)
    );

    // Polarity and enable handling
    assign req_act   = ~req_ni & en_mask;
    assign dma_req   = ~dma_req_ni;
    assign owner_oh  = NUM_MASTERS'(1) << r_q.owner;
    assign owner_req = |(req_act & owner_oh);
    assign others    = req_act & ~owner_oh;
    assign pick_oh   = NUM_MASTERS'(1) << pick_idx;

    lbus_arb_rrpick #(
        .NUM_MASTERS(NUM_MASTERS)
    ) rrpick_i (
        .req_i  (req_act),
        .last_i (r_q.last),
        .valid_o(pick_valid),
        .idx_o  (pick_idx)
    );

    lbus_arb_tenure #(
        .TENURE(TENURE)
    ) tenure_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tenure_start),
        .run_i    (r_q.state == ST_OWN),
        .expired_o(tenure_expired)
    );

    always_comb begin
        r_d          = r_q;
        tenure_start = 1'b0;
        pick_ok      = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                pick_ok = 1'b1;
            end
            ST_OWN: begin
                if (!owner_req) begin
                    // owner let go on its own: free the bus
                    r_d.state = ST_IDLE;
                    r_d.gnt   = '0;
                end else if (dma_req || (tenure_expired && (|others))) begin
                    // preemption: withdraw and wait for release
                    r_d.state = ST_DRAIN;
                    r_d.gnt   = '0;
                end
            end
            ST_DRAIN: begin
                pick_ok = !owner_req;
            end
            ST_DMA: begin
                if (!dma_req) begin
                    r_d.state   = ST_IDLE;
                    r_d.dma_gnt = 1'b0;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (pick_ok) begin
            if (dma_req) begin
                r_d.state   = ST_DMA;
                r_d.dma_gnt = 1'b1;
                r_d.gnt     = '0;
            end else if (pick_valid) begin
                r_d.state    = ST_OWN;
                r_d.owner    = pick_idx;
                r_d.last     = pick_idx;
                r_d.gnt      = pick_oh;
                tenure_start = 1'b1;
            end else begin
                r_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= ST_IDLE;
            r_q.owner   <= '0;
            r_q.last    <= IW'(NUM_MASTERS - 1);
            r_q.gnt     <= '0;
            r_q.dma_gnt <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gnt_no     = ~r_q.gnt;
    assign dma_gnt_no = ~r_q.dma_gnt;

endmodule

// File: rtl/lbus_preempt_arb_chk.sv
module lbus_preempt_arb_chk #(
    parameter int unsigned NUM_MASTERS = 3,
    parameter int unsigned TENURE      = 31,
    parameter int unsigned CFG_W       = 2
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NUM_MASTERS-1:0] req_ni,
    input logic [CFG_W-1:0]       num_en_i,
    input logic                   dma_req_ni,
    input logic [NUM_MASTERS-1:0] gnt_no,
    input logic                   dma_gnt_no
);
    localparam int unsigned HW = $clog2(TENURE + 1);

    logic [NUM_MASTERS-1:0] act_local;
    logic [NUM_MASTERS:0]   act_all;
    logic [NUM_MASTERS-1:0] req_act;
    logic [NUM_MASTERS-1:0] en_chk;
    logic [NUM_MASTERS-1:0] prev_local;
    logic [HW-1:0]          hold_q;
    logic                   dma_act;
    int                     en_cnt;

    assign act_local = ~gnt_no;
    assign dma_act   = ~dma_gnt_no;
    assign act_all   = {dma_act, act_local};
    assign req_act   = ~req_ni;

    always_comb begin
        en_cnt = int'(num_en_i);
        if (en_cnt < 2) en_cnt = 2;
        if (en_cnt > int'(NUM_MASTERS)) en_cnt = int'(NUM_MASTERS);
        for (int i = 0; i < NUM_MASTERS; i++) en_chk[i] = (i < en_cnt);
    end

    // Consecutive cycles the same local grant has been observed low
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_local <= '0;
            hold_q     <= '0;
        end else begin
            prev_local <= act_local;
            if (act_local == '0)              hold_q <= '0;
            else if (act_local != prev_local) hold_q <= HW'(1);
            else if (hold_q < HW'(TENURE))    hold_q <= hold_q + 1'b1;
        end
    end

    // R2
    a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(act_all));

    // R3
    a_r3_break_before_make: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(act_all & ~$past(act_all))) |-> ($past(act_all) == '0));

    // R5
    a_r5_min_tenure: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act_local == '0) && ($past(act_local) != '0)
         && (|($past(act_local) & $past(req_act) & $past(en_chk)))
         && $past(dma_req_ni))
        |-> (hold_q >= HW'(TENURE)));

    // R9
    a_r9_dma_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act_local != '0) && !dma_req_ni) |=> (act_local == '0));

    // R10
    a_r10_dma_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_act && !dma_req_ni) |=> dma_act);

    // R11
    a_r11_disabled_never_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_local & ~$past(act_local) & ~$past(en_chk)) == '0);

endmodule

bind lbus_preempt_arb lbus_preempt_arb_chk #(
    .NUM_MASTERS(NUM_MASTERS),
    .TENURE     (TENURE),
    .CFG_W      (CFG_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_ni    (req_ni),
    .num_en_i  (num_en_i),
    .dma_req_ni(dma_req_ni),
    .gnt_no    (gnt_no),
    .dma_gnt_no(dma_gnt_no)
);

// File: tb/lbus_preempt_arb_tb_top.sv
`timescale 1ns/1ps
module lbus_preempt_arb_tb_top;
    localparam int NM  = 3;
    localparam int TEN = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req_n = '1;
    logic [1:0]    num_en = 2'd3;
    logic          dma_req_n = 1'b1;
    logic [NM-1:0] gnt_n;
    logic          dma_gnt_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    lbus_preempt_arb #(.NUM_MASTERS(NM), .TENURE(TEN), .CFG_W(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .num_en_i(num_en),
        .dma_req_ni(dma_req_n), .gnt_no(gnt_n), .dma_gnt_no(dma_gnt_n));

    function automatic bit onehot0(logic [NM:0] v);
        return ($countones(v) <= 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Counts cycles master i keeps its grant, starting in a cycle already granted
    task automatic count_tenure(input int i, output int n);
        n = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (gnt_n[i] == 1'b0) n++;
            else break;
        end
    endtask

    task automatic rand_phase(input int ncyc, input int en);
        logic [NM:0] all_g;
        logic [NM:0] prev_all;
        int gcnt[NM];
        int hold[NM];
        bit seen[NM];
        int dhold;
        prev_all = '0;
        dhold = 0;
        for (int i = 0; i < NM; i++) begin gcnt[i] = 0; hold[i] = 0; seen[i] = 0; end
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            all_g = {~dma_gnt_n, ~gnt_n};
            chk("R2 one grant at most", int'(onehot0(all_g)), 1);
            if ((all_g & ~prev_all) != '0) chk("R3 gap before new grant", int'(prev_all), 0);
            for (int i = 0; i < NM; i++) begin
                if (prev_all[i] && !all_g[i] && !req_n[i] && dma_req_n && i < en)
                    chk("R5 contended tenure at least 31", int'(gcnt[i] >= TEN), 1);
                gcnt[i] = all_g[i] ? gcnt[i] + 1 : 0;
            end
            if (en < NM) chk("R11 disabled pair grant", int'(all_g[NM-1]), 0);
            prev_all = all_g;
            for (int i = 0; i < NM; i++) begin
                if (i >= en) begin
                    req_n[i] = 1'($urandom % 2);
                end else if (req_n[i]) begin
                    if ($urandom % 8 == 0) begin
                        req_n[i] = 1'b0;
                        hold[i] = 5 + int'($urandom % 60);
                        seen[i] = 0;
                    end
                end else if (all_g[i]) begin
                    seen[i] = 1;
                    if (hold[i] == 0) req_n[i] = 1'b1;
                    else hold[i]--;
                end else if (seen[i]) begin
                    req_n[i] = 1'b1;
                end
            end
            if (dma_req_n) begin
                if ($urandom % 40 == 0) begin
                    dma_req_n = 1'b0;
                    dhold = 1 + int'($urandom % 10);
                end
            end else if (all_g[NM]) begin
                if (dhold == 0) dma_req_n = 1'b1;
                else dhold--;
            end
        end
        req_n = '1;
        dma_req_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 bus idle after all release", int'(gnt_n), 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL ALL: watchdog actual timeout expected finish");
        summary();
    end

    initial begin
        int n;
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        chk("R1 grants in reset", int'(gnt_n), 7);
        chk("R1 dma grant in reset", int'(dma_gnt_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grants after reset", int'(gnt_n), 7);

        // R4: idle bus responds in one edge
        req_n[0] = 1'b0;
        @(negedge clk);
        chk("R4 idle grant latency", int'(gnt_n), 6);
        // R12: uncontended owner keeps grant
        n = 0;
        repeat (40) begin @(negedge clk); if (gnt_n[0]) n++; end
        chk("R12 uncontended hold", n, 0);
        // R8: release frees the bus next edge
        req_n[0] = 1'b1;
        @(negedge clk);
        chk("R8 release drops grant", int'(gnt_n), 7);

        // R5/R6: contended tenure and release handshake
        req_n[0] = 1'b0;
        @(negedge clk);
        chk("R4 grant master0", int'(gnt_n), 6);
        req_n[1] = 1'b0;
        count_tenure(0, n);
        chk("R5 contended tenure exact", n, TEN);
        chk("R3 no grant in handover", int'(gnt_n), 7);
        n = 0;
        repeat (5) begin @(negedge clk); if (gnt_n != 3'b111) n++; end
        chk("R6 waits for release", n, 0);
        req_n[0] = 1'b1;
        @(negedge clk);
        chk("R6 grant after release", int'(gnt_n), 5);

        // R7: round robin 1 -> 2 -> 0
        req_n[0] = 1'b0;
        req_n[2] = 1'b0;
        count_tenure(1, n);
        chk("R5 tenure of master1", n, TEN);
        req_n[1] = 1'b1;
        @(negedge clk);
        chk("R7 next after 1 is 2", int'(gnt_n), 3);
        count_tenure(2, n);
        chk("R5 tenure of master2", n, TEN);
        req_n[2] = 1'b1;
        @(negedge clk);
        chk("R7 wrap to 0", int'(gnt_n), 6);

        // R8: early release hands over without tenure
        req_n[2] = 1'b0;
        repeat (4) @(negedge clk);
        req_n[0] = 1'b1;
        @(negedge clk);
        chk("R8 early release drop", int'(gnt_n), 7);
        @(negedge clk);
        chk("R8 early handover", int'(gnt_n), 3);

        // R9/R10: DMA preemption
        req_n[0] = 1'b0;
        dma_req_n = 1'b0;
        @(negedge clk);
        chk("R9 dma withdraws at once", int'(gnt_n), 7);
        chk("R10 no dma grant before release", int'(dma_gnt_n), 1);
        n = 0;
        repeat (3) begin @(negedge clk); if (!dma_gnt_n || gnt_n != 3'b111) n++; end
        chk("R10 dma waits for release", n, 0);
        req_n[2] = 1'b1;
        @(negedge clk);
        chk("R10 dma granted over waiting master", int'(dma_gnt_n), 0);
        chk("R10 local idle during dma", int'(gnt_n), 7);
        n = 0;
        repeat (10) begin @(negedge clk); if (dma_gnt_n) n++; end
        chk("R10 dma held while requested", n, 0);
        dma_req_n = 1'b1;
        @(negedge clk);
        chk("R10 dma drop", int'(dma_gnt_n), 1);
        @(negedge clk);
        chk("R7 waiting master after dma", int'(gnt_n), 6);

        // R11: disabled pair ignored
        req_n[0] = 1'b1;
        @(negedge clk);
        num_en = 2'd2;
        req_n[2] = 1'b0;
        n = 0;
        repeat (10) begin @(negedge clk); if (gnt_n != 3'b111) n++; end
        chk("R11 disabled request ignored", n, 0);
        num_en = 2'd3;
        @(negedge clk);
        chk("R11 enabled again granted", int'(gnt_n), 3);
        req_n[2] = 1'b1;
        @(negedge clk);
        chk("R8 release master2", int'(gnt_n), 7);

        rand_phase(4000, 3);
        num_en = 2'd2;
        rand_phase(3000, 2);
        summary();
    end
endmodule